// File: doc/BRIEF.md
# Multi-Converter Result Packing and DMA Sequencer

This block sits between two or three converters that are triggered together and a DMA engine. Each converter reports a 16-bit result with a one-cycle end-of-conversion strobe. The block waits until every participating converter has reported for the current channel, and strobes may arrive in different cycles. Once that happens it treats the channel as jointly complete and moves the results into one shared 32-bit data register.

Two DMA modes are supported. In the packed mode, both results of a dual pair share one 32-bit word and one request. In the serial mode, each participating converter's result goes out as its own word and request, in a fixed order. Each request stays asserted until it is acknowledged, and the data register advances only on an acknowledge. If a new joint completion arrives while transfers are still pending, a sticky overrun flag is set and the new data is dropped.

A channel counter spans the regular group of up to 16 channels. At the end of the group the block raises a sticky interrupt flag if any participating converter has its interrupt enabled. The flag is cleared by a write-one-to-clear pulse.

Top module: `mconv_dma_seq`

## Requirements
- R1: A joint completion occurs only when every participating converter has strobed `eoc_i` since the last joint completion; strobes may arrive in separate cycles, and each converter's latest result is used. The data register and request change in the cycle after the final strobe.
- R2: With `dma_mode_i` = 2'b10, each joint completion raises exactly one request, and `cdr_o` = {converter 1 result, converter 0 result} (converter 1 in bits 31:16).
- R3: With `dma_mode_i` = 2'b01, each joint completion yields one request per participating converter, in the order converter 0, 1, 2. Each word is {16'h0000, result}.
- R4: `dma_req_o` stays high and `cdr_o` stays stable until `dma_ack_i` is sampled high. An acknowledge advances to the next queued word, or drops the request after the last word.
- R5: A joint completion while `dma_req_o` is high sets `ovr_o`. The new data is dropped: `cdr_o` and the pending transfers are unchanged. `ovr_o` stays set until reset.
- R6: With `dma_mode_i` = 2'b00 or 2'b11, no request is raised, and `cdr_o` takes the packed word {converter 1, converter 0} at each joint completion.
- R7: After `seq_len_i`+1 joint completions, `irq_o` sets if `irq_en_i` has a bit set for any participating converter. An enable bit for a non-participating converter has no effect.
- R8: `irq_o` is sticky and is cleared by an `irq_clr_i` pulse. A set in the same cycle as the clear wins.
- R9: With `triple_i` = 0, only converters 0 and 1 participate. A strobe from converter 2 neither completes nor contributes to a joint completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eoc_i | input | 3 | Per-converter end-of-conversion strobes |
| res_i | input | 48 | Per-converter results, converter k in bits 16k+15:16k |
| dma_mode_i | input | 2 | 00/11 off, 01 serial, 10 packed |
| triple_i | input | 1 | 1: three converters participate, 0: two |
| irq_en_i | input | 3 | Per-converter interrupt enables |
| seq_len_i | input | 4 | Regular group length minus one |
| dma_ack_i | input | 1 | DMA acknowledge of the current word |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| cdr_o | output | 32 | Common data word |
| dma_req_o | output | 1 | DMA request |
| irq_o | output | 1 | End-of-group interrupt flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest cases to reach are the ones where the timing between converters and the DMA side matters. One is an overrun that must leave the queued word untouched. The other is a converter strobe arriving alone, either ahead of its partner or from a converter that is not participating. The bench gets there with directed tasks. Converter strobes are fired with chosen masks in separate cycles, and the acknowledge is held back across a second joint completion. The same-cycle clear and set of the interrupt is also driven on purpose, using a one-channel group.

// File: rtl/mconv_pkg.sv
package mconv_pkg;
  typedef enum logic [1:0] {
    XFER_OFF    = 2'b00,
    XFER_SERIAL = 2'b01,
    XFER_PACKED = 2'b10,
    XFER_OFF_B  = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/mconv_collect.sv
module mconv_collect #(
  parameter int N_CONV = 3,
  parameter int RES_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CONV-1:0]       eoc_i,
  input  logic [N_CONV*RES_W-1:0] res_i,
  input  logic [N_CONV-1:0]       part_i,
  output logic                    joint_o,
  output logic [N_CONV*RES_W-1:0] res_o
);
  logic [N_CONV-1:0]       seen_q;
  logic [N_CONV*RES_W-1:0] hold_q;
  logic [N_CONV-1:0]       done;
  logic [N_CONV-1:0]       hit;

  assign hit     = eoc_i & part_i;
  assign done    = seen_q | hit | ~part_i;
  assign joint_o = (&done) && (|hit);

  for (genvar k = 0; k < N_CONV; k++) begin : g_conv
    assign res_o[k*RES_W +: RES_W] = eoc_i[k] ? res_i[k*RES_W +: RES_W]
                                              : hold_q[k*RES_W +: RES_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       hold_q[k*RES_W +: RES_W] <= '0;
      else if (eoc_i[k]) hold_q[k*RES_W +: RES_W] <= res_i[k*RES_W +: RES_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= '0;
    else if (joint_o) seen_q <= '0;
    else              seen_q <= seen_q | hit;
  end

  // R1: completion needs a participating strobe in the same cycle
  a_r1_joint_needs_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    joint_o |-> |(eoc_i & part_i));
  // R9: a non-participant strobe alone never completes
  a_r9_nonpart_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eoc_i & part_i) == '0) |-> !joint_o);
endmodule

// File: rtl/mconv_seq_cnt.sv
module mconv_seq_cnt #(
  parameter int N_CONV = 3,
  parameter int CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              joint_i,
  input  logic [CH_W-1:0]   seq_len_i,
  input  logic [N_CONV-1:0] irq_en_i,
  input  logic [N_CONV-1:0] part_i,
  input  logic              irq_clr_i,
  output logic              irq_o
);
  logic [CH_W-1:0] ch_q;
  logic            seq_end;
  logic            irq_set;
  logic            irq_q;

  assign seq_end = joint_i && (ch_q == seq_len_i);
  assign irq_set = seq_end && |(irq_en_i & part_i);
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ch_q <= '0;
    else if (seq_end) ch_q <= '0;
    else if (joint_i) ch_q <= ch_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  a_r8_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !irq_set) |=> !irq_q);
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  a_r7_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set |=> irq_q);
endmodule

// File: rtl/mconv_xfer.sv
module mconv_xfer
  import mconv_pkg::*;
#(
  parameter int N_CONV = 3,
  parameter int RES_W  = 16,
  localparam int DW    = 2 * RES_W,
  localparam int IDX_W = (N_CONV > 1) ? $clog2(N_CONV) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    joint_i,
  input  logic [N_CONV*RES_W-1:0] res_i,
  input  xfer_mode_e              mode_i,
  input  logic [IDX_W-1:0]        last_i,
  input  logic                    ack_i,
  output logic [DW-1:0]           cdr_o,
  output logic                    req_o,
  output logic                    ovr_o
);
  logic [N_CONV*RES_W-1:0] res_q;
  logic [IDX_W-1:0]        idx_q, last_q;
  logic [DW-1:0]           cdr_q;
  logic                    req_q, ovr_q;
  logic [DW-1:0]           packed_w;
  logic                    load;
  logic                    adv;
  logic [IDX_W-1:0]        nxt_idx;

  assign packed_w = {res_i[2*RES_W-1:RES_W], res_i[RES_W-1:0]};
  assign load     = joint_i && !req_q;
  assign adv      = req_q && ack_i;
  assign nxt_idx  = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      cdr_q  <= '0;
      req_q  <= 1'b0;
    end else if (load) begin
      res_q <= res_i;
      idx_q <= '0;
      unique case (mode_i)
        XFER_SERIAL: begin
          last_q <= last_i;
          cdr_q  <= {{(DW-RES_W){1'b0}}, res_i[RES_W-1:0]};
          req_q  <= 1'b1;
        end
        XFER_PACKED: begin
          last_q <= '0;
          cdr_q  <= packed_w;
          req_q  <= 1'b1;
        end
        default: begin
          last_q <= '0;
          cdr_q  <= packed_w;
          req_q  <= 1'b0;
        end
      endcase
    end else if (adv) begin
      if (idx_q == last_q) begin
        req_q <= 1'b0;
      end else begin
        idx_q <= nxt_idx;
        cdr_q <= {{(DW-RES_W){1'b0}}, res_q[nxt_idx*RES_W +: RES_W]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovr_q <= 1'b0;
    else if (joint_i && req_q)  ovr_q <= 1'b1;
  end

  assign cdr_o = cdr_q;
  assign req_o = req_q;
  assign ovr_o = ovr_q;

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable(cdr_q)));
  a_r5_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (joint_i && req_q) |=> ovr_q);
  a_r5_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  a_r6_off_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && (mode_i == XFER_OFF || mode_i == XFER_OFF_B)) |=> !req_q);
  a_r2_packed_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && mode_i == XFER_PACKED) |=>
      (req_q && cdr_q == {$past(res_i[2*RES_W-1:RES_W]), $past(res_i[RES_W-1:0])}));
  a_r3_serial_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && mode_i == XFER_SERIAL) |=>
      (req_q && cdr_q[RES_W-1:0] == $past(res_i[RES_W-1:0]) && cdr_q[DW-1:RES_W] == '0));
endmodule

// File: rtl/mconv_dma_seq.sv
module mconv_dma_seq
  import mconv_pkg::*;
#(
  parameter int N_CONV = 3,
  parameter int RES_W  = 16,
  parameter int CH_W   = 4,
  localparam int DW    = 2 * RES_W,
  localparam int IDX_W = (N_CONV > 1) ? $clog2(N_CONV) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CONV-1:0]       eoc_i,
  input  logic [N_CONV*RES_W-1:0] res_i,
  input  logic [1:0]              dma_mode_i,
  input  logic                    triple_i,
  input  logic [N_CONV-1:0]       irq_en_i,
  input  logic [CH_W-1:0]         seq_len_i,
  input  logic                    dma_ack_i,
  input  logic                    irq_clr_i,
  output logic [DW-1:0]           cdr_o,
  output logic                    dma_req_o,
  output logic                    irq_o,
  output logic                    ovr_o
);
  logic [N_CONV-1:0]       part;
  logic                    joint;
  logic [N_CONV*RES_W-1:0] res_cur;
  logic [IDX_W-1:0]        last_idx;

  // converters 0 and 1 always take part; higher ones only in triple mode
  for (genvar k = 0; k < N_CONV; k++) begin : g_part
    if (k < 2) begin : g_base
      assign part[k] = 1'b1;
    end else begin : g_ext
      assign part[k] = triple_i;
    end
  end

  assign last_idx = triple_i ? IDX_W'(N_CONV - 1) : IDX_W'(1);

  mconv_collect #(.N_CONV(N_CONV), .RES_W(RES_W)) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eoc_i   (eoc_i),
    .res_i   (res_i),
    .part_i  (part),
    .joint_o (joint),
    .res_o   (res_cur)
  );

  mconv_xfer #(.N_CONV(N_CONV), .RES_W(RES_W)) u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .joint_i(joint),
    .res_i  (res_cur),
    .mode_i (xfer_mode_e'(dma_mode_i)),
    .last_i (last_idx),
    .ack_i  (dma_ack_i),
    .cdr_o  (cdr_o),
    .req_o  (dma_req_o),
    .ovr_o  (ovr_o)
  );

  mconv_seq_cnt #(.N_CONV(N_CONV), .CH_W(CH_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .joint_i  (joint),
    .seq_len_i(seq_len_i),
    .irq_en_i (irq_en_i),
    .part_i   (part),
    .irq_clr_i(irq_clr_i),
    .irq_o    (irq_o)
  );

  a_r4_ack_idle_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_req_o && !joint) |=> (!dma_req_o && $stable(cdr_o)));
endmodule

// File: tb/mconv_dma_seq_bench.sv
module mconv_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  eoc = '0;
  logic [47:0] res = '0;
  logic [1:0]  mode = 2'b00;
  logic        triple = 1'b0;
  logic [2:0]  irq_en = '0;
  logic [3:0]  seq_len = '0;
  logic        ack = 1'b0;
  logic        irq_clr = 1'b0;
  logic [31:0] cdr;
  logic        req, irq, ovr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mconv_dma_seq u_mconv_dma_seq (
    .clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc), .res_i(res),
    .dma_mode_i(mode), .triple_i(triple), .irq_en_i(irq_en),
    .seq_len_i(seq_len), .dma_ack_i(ack), .irq_clr_i(irq_clr),
    .cdr_o(cdr), .dma_req_o(req), .irq_o(irq), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic tr);
    @(negedge clk);
    rst_n = 1'b0; eoc = '0; ack = 1'b0; irq_clr = 1'b0;
    mode = m; triple = tr; irq_en = '0; seq_len = 4'd15;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fire(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    eoc = m; res = {c, b, a};
    @(negedge clk);
    eoc = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'b10, 1'b0);
    chk_eq("R4 reset cdr", cdr, 32'h0);
    chk_eq("R4 reset req", {31'b0, req}, 32'h0);
    chk_eq("R7 reset irq", {31'b0, irq}, 32'h0);
    chk_eq("R5 reset ovr", {31'b0, ovr}, 32'h0);
  endtask

  task automatic t_packed(); // R2
    do_reset(2'b10, 1'b0);
    fire(3'b011, 16'h1111, 16'h2222, 16'h0);
    chk_eq("R2 packed word", cdr, 32'h2222_1111);
    chk_eq("R2 packed req", {31'b0, req}, 32'h1);
    pulse_ack();
    chk_eq("R2 single request", {31'b0, req}, 32'h0);
    fire(3'b011, 16'hABCD, 16'h1234, 16'h0);
    chk_eq("R2 packed word 2", cdr, 32'h1234_ABCD);
    pulse_ack();
  endtask

  task automatic t_serial(); // R3
    do_reset(2'b01, 1'b1);
    fire(3'b111, 16'h00A1, 16'h00B2, 16'h00C3);
    chk_eq("R3 word conv0", cdr, 32'h0000_00A1);
    chk_eq("R3 req 1", {31'b0, req}, 32'h1);
    pulse_ack();
    chk_eq("R3 word conv1", cdr, 32'h0000_00B2);
    chk_eq("R3 req 2", {31'b0, req}, 32'h1);
    pulse_ack();
    chk_eq("R3 word conv2", cdr, 32'h0000_00C3);
    chk_eq("R3 req 3", {31'b0, req}, 32'h1);
    pulse_ack();
    chk_eq("R3 done after three", {31'b0, req}, 32'h0);
    fire(3'b111, 16'hF001, 16'hF002, 16'hF003);
    chk_eq("R3 restart conv0", cdr, 32'h0000_F001);
    pulse_ack(); pulse_ack(); pulse_ack();
    chk_eq("R3 restart done", {31'b0, req}, 32'h0);
  endtask

  task automatic t_dual_serial(); // R3 with two participants
    do_reset(2'b01, 1'b0);
    fire(3'b011, 16'h0011, 16'h0022, 16'h0033);
    pulse_ack();
    chk_eq("R3 dual second word", cdr, 32'h0000_0022);
    pulse_ack();
    chk_eq("R3 dual two requests", {31'b0, req}, 32'h0);
  endtask

  task automatic t_stagger(); // R1
    do_reset(2'b10, 1'b0);
    fire(3'b001, 16'h0AAA, 16'h0, 16'h0);
    chk_eq("R1 partial no req", {31'b0, req}, 32'h0);
    @(negedge clk);
    fire(3'b010, 16'h0, 16'h0BBB, 16'h0);
    chk_eq("R1 joint req", {31'b0, req}, 32'h1);
    chk_eq("R1 joint word", cdr, 32'h0BBB_0AAA);
    pulse_ack();
  endtask

  task automatic t_hold(); // R4
    do_reset(2'b01, 1'b1);
    fire(3'b111, 16'h0101, 16'h0202, 16'h0303);
    repeat (5) @(negedge clk);
    chk_eq("R4 req held", {31'b0, req}, 32'h1);
    chk_eq("R4 cdr held", cdr, 32'h0000_0101);
  endtask

  task automatic t_overrun(); // R5
    do_reset(2'b10, 1'b0);
    fire(3'b011, 16'h0001, 16'h0002, 16'h0);
    chk_eq("R5 no ovr yet", {31'b0, ovr}, 32'h0);
    fire(3'b011, 16'h0003, 16'h0004, 16'h0);
    chk_eq("R5 ovr set", {31'b0, ovr}, 32'h1);
    chk_eq("R5 data kept", cdr, 32'h0002_0001);
    pulse_ack();
    chk_eq("R5 no extra request", {31'b0, req}, 32'h0);
    fire(3'b011, 16'h0005, 16'h0006, 16'h0);
    chk_eq("R5 next word", cdr, 32'h0006_0005);
    chk_eq("R5 ovr sticky", {31'b0, ovr}, 32'h1);
  endtask

  task automatic t_nodma(); // R6
    do_reset(2'b00, 1'b0);
    fire(3'b011, 16'h4444, 16'h5555, 16'h0);
    chk_eq("R6 off no req", {31'b0, req}, 32'h0);
    chk_eq("R6 off word", cdr, 32'h5555_4444);
    mode = 2'b11;
    fire(3'b011, 16'h6666, 16'h7777, 16'h0);
    chk_eq("R6 mode11 no req", {31'b0, req}, 32'h0);
    chk_eq("R6 mode11 word", cdr, 32'h7777_6666);
  endtask

  task automatic t_dual_ignore(); // R9
    do_reset(2'b10, 1'b0);
    fire(3'b100, 16'h0, 16'h0, 16'h9999);
    chk_eq("R9 conv2 alone no req", {31'b0, req}, 32'h0);
    fire(3'b001, 16'h0123, 16'h0, 16'h0);
    chk_eq("R9 conv0 alone no req", {31'b0, req}, 32'h0);
    fire(3'b110, 16'h0, 16'h0456, 16'h8888);
    chk_eq("R9 joint without conv2", cdr, 32'h0456_0123);
    pulse_ack();
  endtask

  task automatic t_irq(); // R7 R8
    do_reset(2'b00, 1'b0);
    seq_len = 4'd2; irq_en = 3'b001;
    fire(3'b011, 16'h1, 16'h2, 16'h0);
    fire(3'b011, 16'h1, 16'h2, 16'h0);
    chk_eq("R7 irq not early", {31'b0, irq}, 32'h0);
    fire(3'b011, 16'h1, 16'h2, 16'h0);
    chk_eq("R7 irq at group end", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk_eq("R8 irq sticky", {31'b0, irq}, 32'h1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk_eq("R8 irq cleared", {31'b0, irq}, 32'h0);
    irq_en = 3'b100;
    repeat (3) fire(3'b011, 16'h1, 16'h2, 16'h0);
    chk_eq("R7 non-participant enable ignored", {31'b0, irq}, 32'h0);
    triple = 1'b1;
    repeat (3) fire(3'b111, 16'h1, 16'h2, 16'h3);
    chk_eq("R7 triple conv2 enable", {31'b0, irq}, 32'h1);
    seq_len = 4'd0; irq_en = 3'b010;
    irq_clr = 1'b1;
    fire(3'b111, 16'h1, 16'h2, 16'h3);
    irq_clr = 1'b0;
    chk_eq("R8 set wins over clear", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_packed();
    t_serial();
    t_dual_serial();
    t_stagger();
    t_hold();
    t_overrun();
    t_nodma();
    t_dual_ignore();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule